// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer

The block holds three independent 32-bit down-counters behind one simple register bus. Each channel has a reload limit, a live count, a control byte, and a sticky expiry flag. Each flag drives its own interrupt line through a per-channel mask bit. Channel 0 advances on the `tick_fast` enable and channels 1 and 2 on the `tick_slow` enable. A per-channel prescaler can divide the tick by 1, 16 or 256.

Each channel runs in one of three modes. In one-shot mode it expires once and then parks at zero. In free-running mode it wraps to 0xFFFF or 0xFFFFFFFF. In periodic mode it reloads from its limit. Software can set the limit alone, or the limit and the live count together. Reads are combinational from the address. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `tri_down_timer`

## Requirements
- R1: The channel is selected by addr[9:8] and the word within the channel by addr[7:2]. Channel index 3 reads as zero and ignores writes. Unmapped words (7 and above) read as zero and ignore writes.
- R2: A write to word 0 sets both the limit and the count to wdata, and restarts the prescaler. Words 0 and 6 both read back the limit.
- R3: A write to word 6 changes the limit only. The count keeps its value.
- R4: Word 1 reads the live count. Writes to word 1 change nothing.
- R5: Word 2 reads and writes the control byte in bits [7:0], with bits [31:8] reading as zero. The control bits are: bit 7 enable, bit 6 periodic, bit 5 interrupt mask, bits [3:2] prescale, bit 1 wide wrap, bit 0 one-shot. Prescale 1 divides the tick by 16, prescale 2 by 256, and prescale 0 or 3 by 1. A write to word 0 or word 2 clears the prescaler, so the first step comes on the Nth tick after that write. A tick in the write cycle itself is not counted.
- R6: A step that finds the count above 1 decrements it. A step that finds the count at 1, or at 0 outside one-shot mode, is an expiry. In one-shot mode the expiry leaves the count at 0, and later steps do nothing.
- R7: On expiry in free-running mode (bit 6 = 0, bit 0 = 0), the count becomes 0xFFFFFFFF if bit 1 is set and 0x0000FFFF if bit 1 is clear. In periodic mode (bit 6 = 1) the count becomes the limit.
- R8: An expiry sets the raw flag. A write to word 3 clears it, but an expiry in the same cycle wins. Word 4 reads the raw flag in bit 0. Word 5 reads the raw flag ANDed with control bit 5.
- R9: irq[n] is high exactly when channel n's raw flag and control bit 5 are both set.
- R10: After reset, each control byte is 0x20, each count is 0xFFFFFFFF, each limit is 0, and each raw flag is clear.
- R11: While bit 7 is clear, the count and prescaler hold their values. A control write leaves the count unchanged, and counting resumes from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Tick enable for channel 0 |
| tick_slow | input | 1 | Tick enable for channels 1 and 2 |
| wr_en | input | 1 | Write strobe |
| addr | input | 10 | Byte address: channel [9:8], word [7:2] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 3 | Per-channel masked interrupt |

## Verification
Two things can land on the same edge: a software clear of the raw flag and a fresh expiry. To provoke this, a channel is run periodic with a limit of 0 and a tick on every cycle, so that it expires on every edge. The flag-clear write is then issued while the ticks continue. Word 4 must still read 1 afterwards, and it must fall only after the clear is repeated with the ticks stopped. The same collision occurs in a long random phase, where the bench's cycle model judges every cycle.

// File: rtl/tri_tmr_pkg.sv
package tri_tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_CH   = 3;
    localparam int ADDR_W   = 10;
    localparam int CH_LSB   = 8;
    localparam int CH_W     = ADDR_W - CH_LSB;
    localparam int WORD_LSB = 2;
    localparam int WORD_W   = CH_LSB - WORD_LSB;
    localparam int PRE_W    = 8;

    typedef enum logic [WORD_W-1:0] {
        W_LOAD   = 6'd0,
        W_VALUE  = 6'd1,
        W_CTRL   = 6'd2,
        W_ICLR   = 6'd3,
        W_RAW    = 6'd4,
        W_MASKED = 6'd5,
        W_BGLOAD = 6'd6
    } word_e;

    typedef struct packed {
        logic       enable;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] pre;
        logic       wide;
        logic       one_shot;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = 8'h20;

    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
        case (sel)
            2'd1:    pre_limit = PRE_W'(15);
            2'd2:    pre_limit = PRE_W'(255);
            default: pre_limit = '0;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tri_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       step
);
    logic [PRE_W-1:0] pc;
    logic [PRE_W-1:0] lim;

    assign lim  = pre_limit(sel);
    assign step = tick && run && !restart && (pc == lim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pc <= '0;
        end else if (tick && run) begin
            pc <= (pc == lim) ? '0 : pc + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tri_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_load,
    input  logic              wr_bg,
    input  logic              wr_ctrl,
    input  logic              wr_iclr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] limit,
    output logic [DATA_W-1:0] count,
    output ctrl_t             ctrl,
    output logic              raw,
    output logic              irq
);
    logic              step;
    logic              parked;
    logic              expire;
    logic [DATA_W-1:0] count_nxt;

    tmr_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (ctrl.enable),
        .restart (wr_load || wr_ctrl),
        .sel     (ctrl.pre),
        .step    (step)
    );

    assign parked = ctrl.one_shot && (count == '0);
    assign expire = step && !parked && (count <= DATA_W'(1));

    always_comb begin
        if (!expire)            count_nxt = count - 1'b1;
        else if (ctrl.one_shot) count_nxt = '0;
        else if (ctrl.periodic) count_nxt = limit;
        else if (ctrl.wide)     count_nxt = '1;
        else                    count_nxt = DATA_W'(32'h0000_FFFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit <= '0;
            count <= '1;
            ctrl  <= CTRL_RESET;
            raw   <= 1'b0;
        end else begin
            if (wr_load || wr_bg) limit <= wdata;
            if (wr_load)                count <= wdata;
            else if (step && !parked)   count <= count_nxt;
            if (wr_ctrl) ctrl <= ctrl_t'(wdata[7:0]);
            if (expire)       raw <= 1'b1;
            else if (wr_iclr) raw <= 1'b0;
        end
    end

    assign irq = raw && ctrl.irq_en;

    AST_LOAD_SETS_BOTH: assert property (@(posedge clk) disable iff (rst)
        wr_load |=> (count == $past(wdata)) && (limit == $past(wdata))); // R2
    AST_BG_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (wr_bg && !wr_load && !step) |=> (count == $past(count))); // R3
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !wr_load) |=> $stable(count)); // R11
    AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (rst)
        (ctrl.one_shot && count == '0 && !wr_load) |=> (count == '0)); // R6
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
        (raw && !wr_iclr) |=> raw); // R8
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl.one_shot && !ctrl.periodic && !wr_load)
        |=> (count == ($past(ctrl.wide) ? {DATA_W{1'b1}} : DATA_W'(32'h0000_FFFF)))); // R7
endmodule

// File: rtl/tri_down_timer.sv
module tri_down_timer
    import tri_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [CH_W-1:0]   ch_idx;
    word_e             word;
    logic [DATA_W-1:0] limit_a [NUM_CH];
    logic [DATA_W-1:0] count_a [NUM_CH];
    ctrl_t             ctrl_a  [NUM_CH];
    logic              raw_a   [NUM_CH];

    assign ch_idx = addr[ADDR_W-1:CH_LSB];
    assign word   = word_e'(addr[CH_LSB-1:WORD_LSB]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = wr_en && (ch_idx == CH_W'(g));
        tmr_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    ((g == 0) ? tick_fast : tick_slow),
            .wr_load (sel && word == W_LOAD),
            .wr_bg   (sel && word == W_BGLOAD),
            .wr_ctrl (sel && word == W_CTRL),
            .wr_iclr (sel && word == W_ICLR),
            .wdata   (wdata),
            .limit   (limit_a[g]),
            .count   (count_a[g]),
            .ctrl    (ctrl_a[g]),
            .raw     (raw_a[g]),
            .irq     (irq[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CH_W'(i)) begin
                case (word)
                    W_LOAD, W_BGLOAD: rdata = limit_a[i];
                    W_VALUE:          rdata = count_a[i];
                    W_CTRL:           rdata = DATA_W'(ctrl_a[i]);
                    W_RAW:            rdata = DATA_W'(raw_a[i]);
                    W_MASKED:         rdata = DATA_W'(raw_a[i] && ctrl_a[i].irq_en);
                    default:          rdata = '0;
                endcase
            end
        end
    end

    AST_IRQ_FOLLOWS_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ch_idx == '0 && word == W_MASKED) |-> (rdata[0] == irq[0])); // R9
endmodule

// File: tb/tri_down_timer_test.sv
module tri_down_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit live  = 1'b0;

    logic [31:0] m_limit [3];
    logic [31:0] m_count [3];
    logic [7:0]  m_ctrl  [3];
    bit          m_raw   [3];
    int          m_pc    [3];

    tri_down_timer uut (
        .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] m_read(input logic [9:0] a);
        int c = a[9:8];
        int w = a[7:2];
        if (c > 2) return 32'h0;
        case (w)
            0, 6: return m_limit[c];
            1:    return m_count[c];
            2:    return {24'h0, m_ctrl[c]};
            4:    return {31'h0, m_raw[c]};
            5:    return {31'h0, m_raw[c] & m_ctrl[c][5]};
            default: return 32'h0;
        endcase
    endfunction

    // behavioural model, advanced once per rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < 3; n++) begin
                m_limit[n] = 0; m_count[n] = 32'hFFFF_FFFF;
                m_ctrl[n] = 8'h20; m_raw[n] = 0; m_pc[n] = 0;
            end
        end else begin
            for (int n = 0; n < 3; n++) begin
                bit tk, sel, rs, st, ex, park;
                int dv, w;
                tk  = (n == 0) ? tick_fast : tick_slow;
                sel = wr_en && (addr[9:8] == n[1:0]);
                w   = addr[7:2];
                rs  = sel && (w == 0 || w == 2);
                dv  = (m_ctrl[n][3:2] == 2'd1) ? 16 : (m_ctrl[n][3:2] == 2'd2) ? 256 : 1;
                st  = tk && m_ctrl[n][7] && !rs && (m_pc[n] == dv - 1);
                park = m_ctrl[n][0] && (m_count[n] == 0);
                ex  = st && !park && (m_count[n] <= 1);
                if (rs) m_pc[n] = 0;
                else if (tk && m_ctrl[n][7]) m_pc[n] = (m_pc[n] == dv - 1) ? 0 : m_pc[n] + 1;
                if (sel && w == 0) m_count[n] = wdata;
                else if (ex) begin
                    if (m_ctrl[n][0])      m_count[n] = 0;
                    else if (m_ctrl[n][6]) m_count[n] = m_limit[n];
                    else if (m_ctrl[n][1]) m_count[n] = 32'hFFFF_FFFF;
                    else                   m_count[n] = 32'h0000_FFFF;
                end else if (st && !park) m_count[n] = m_count[n] - 1;
                if (sel && (w == 0 || w == 6)) m_limit[n] = wdata;
                if (sel && w == 2) m_ctrl[n] = wdata[7:0];
                if (ex) m_raw[n] = 1;
                else if (sel && w == 3) m_raw[n] = 0;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live) begin
            logic [2:0] mi;
            for (int n = 0; n < 3; n++) mi[n] = m_raw[n] & m_ctrl[n][5];
            n_cmp++;
            if (irq !== mi) begin
                n_bad++;
                $display("FAIL R9 irq actual=%b expected=%b t=%0t", irq, mi, $time);
            end
            n_cmp++;
            if (rdata !== m_read(addr)) begin
                n_bad++;
                $display("FAIL R1 rdata addr=%h actual=%h expected=%h", addr, rdata, m_read(addr));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int w, input logic [31:0] d);
        @(negedge clk); #1;
        tick_fast = 0; tick_slow = 0;
        wr_en = 1; addr = {ch[1:0], w[5:0], 2'b00}; wdata = d;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input int ch, input int w, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        tick_fast = 0; tick_slow = 0; wr_en = 0;
        addr = {ch[1:0], w[5:0], 2'b00};
        @(negedge clk);
        chk(tag, rdata, exp);
    endtask

    task automatic run(input int cycles, input bit f, input bit s);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #1;
            wr_en = 0; tick_fast = f; tick_slow = s;
            addr = {2'($urandom_range(0, 3)), 6'($urandom_range(0, 7)), 2'b00};
        end
        @(negedge clk); #1;
        tick_fast = 0; tick_slow = 0;
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        live = 1;
        rd(0, 2, 32'h20, "R10 ctrl reset");
        rd(1, 1, 32'hFFFF_FFFF, "R10 count reset");
        rd(2, 0, 32'h0, "R10 limit reset");
        rd(2, 4, 32'h0, "R10 raw reset");

        wr(0, 0, 5);
        rd(0, 0, 5, "R2 limit");
        rd(0, 1, 5, "R2 count");
        wr(0, 6, 9);
        rd(0, 6, 9, "R3 bg limit");
        rd(0, 1, 5, "R3 count kept");
        wr(0, 1, 123);
        rd(0, 1, 5, "R4 value write ignored");
        wr(0, 2, 32'hFFFF_FFE0);
        rd(0, 2, 32'hE0, "R5 ctrl readback");
        run(4, 1, 0);
        rd(0, 1, 1, "R6 decrement");
        rd(0, 4, 0, "R8 no expiry yet");
        run(1, 1, 0);
        rd(0, 1, 9, "R7 periodic reload");
        rd(0, 5, 1, "R8 masked");
        chk("R9 irq0 high", {31'h0, irq[0]}, 1);
        wr(0, 3, 0);
        rd(0, 4, 0, "R8 cleared");
        wr(0, 2, 32'h60);
        run(10, 1, 0);
        rd(0, 1, 9, "R11 disabled holds");
        wr(0, 2, 32'hE0);
        rd(0, 1, 9, "R11 ctrl rewrite keeps count");
        wr(3, 0, 77);
        rd(3, 0, 0, "R1 channel 3 reads zero");
        rd(0, 0, 9, "R1 channel 3 write ignored");

        wr(1, 2, 32'h80);
        wr(1, 0, 2);
        run(2, 0, 1);
        rd(1, 1, 32'h0000_FFFF, "R7 free 16-bit wrap");
        rd(1, 4, 1, "R8 raw free");
        rd(1, 5, 0, "R8 masked off");
        chk("R9 irq1 low", {31'h0, irq[1]}, 0);
        wr(1, 2, 32'h82);
        wr(1, 0, 1);
        run(1, 0, 1);
        rd(1, 1, 32'hFFFF_FFFF, "R7 free 32-bit wrap");
        wr(1, 2, 32'h00);

        wr(2, 2, 32'hA5);
        wr(2, 0, 2);
        run(31, 0, 1);
        rd(2, 1, 1, "R5 divide by 16");
        run(1, 0, 1);
        rd(2, 1, 0, "R6 one-shot expiry");
        rd(2, 4, 1, "R6 one-shot raw");
        run(40, 0, 1);
        rd(2, 1, 0, "R6 one-shot parked");

        wr(0, 0, 0);
        run(3, 1, 0);
        @(negedge clk); #1;
        tick_fast = 1; wr_en = 1; addr = {2'd0, 6'd3, 2'b00}; wdata = 0;
        @(negedge clk); #1;
        wr_en = 0;
        rd(0, 4, 1, "R8 expiry beats clear");
        wr(0, 3, 0);
        rd(0, 4, 0, "R8 clear after ticks stop");

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            tick_fast = ($urandom_range(0, 3) != 0);
            tick_slow = ($urandom_range(0, 3) == 0);
            addr = {2'($urandom_range(0, 3)), 6'($urandom_range(0, 7)), 2'b00};
            wr_en = ($urandom_range(0, 9) == 0);
            wdata = (addr[7:2] == 2) ? 32'($urandom_range(0, 255)) | 32'h80
                                     : 32'($urandom_range(0, 40));
        end
        @(negedge clk); #1;
        wr_en = 0;
        repeat (2) @(negedge clk);
        report();
    end
endmodule